// File: doc/BRIEF.md
# Two-Epoch Undo-Log Checkpoint Memory

This block is a small word-addressed data store that can be rolled back to an earlier checkpoint. A write changes the addressed word in place. When it is the first write to that word since the last checkpoint, the word's previous contents go into a circular undo log, together with the word address and the epoch in which the write happened. Words that are never written keep a single copy, and the checkpointed state and the live state share that copy.

The log always holds two epochs, the current one and the one before it. A checkpoint strobe drops only the entries of the older epoch and opens a new epoch. Because of this, a rollback issued right after a checkpoint still has a full epoch of history to undo. A rollback strobe walks the log from its newest entry back to its oldest, one entry per cycle, and restores each saved word. At the end the store holds the state of the older of the two live checkpoints. While the walk runs, the block raises `busy` and ignores reads and writes. A write that needs a log entry while the log is full has no effect, and `log_full` tells the requester to hold the write until a checkpoint frees space.

Top module: `ckpt_mem`

## Requirements
- R1: After reset every word reads 0, `busy` is low and `log_full` is low.
- R2: With `rd_en` high and `busy` low, `rd_data` shows the addressed word one clock later, as it stood before any write in the same cycle. An accepted write takes effect at that clock edge.
- R3: After a rollback completes, every word holds the value it had at the older of the two most recent checkpoints. Reset counts as a checkpoint at which all words are 0. After the rollback, that restored state is both live checkpoints.
- R4: A rollback issued right after a checkpoint restores the state of the checkpoint before that one, not the one just taken.
- R5: A checkpoint frees only the log entries of the older epoch. The entries of the epoch it closes stay in the log.
- R6: Only the first write to a word within an epoch takes a log entry. Rewriting the same word any number of times does not fill the log.
- R7: While 16 entries are held, a write to a word not yet written in the current epoch is not applied, and `log_full` stays high. A write to a word already written in the current epoch is still applied.
- R8: After a rollback strobe, `busy` is high for exactly N+1 cycles, where N is the number of log entries, starting on the next cycle. Reads and writes issued during this time have no effect, and `rd_data` holds its value.
- R9: If a checkpoint and a write arrive in the same cycle, the checkpoint comes first and the write belongs to the new epoch. If a rollback arrives together with a write or a checkpoint, only the rollback takes effect.
- R10: `log_full` is high exactly when the log holds 16 entries, counting both epochs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Read request |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 8 | Registered read data |
| wr_en | input | 1 | Write request |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 8 | Write data |
| ckpt_strobe | input | 1 | Take a checkpoint (one cycle) |
| rollback_strobe | input | 1 | Start rollback to the older live checkpoint |
| busy | output | 1 | Rollback walk in progress |
| log_full | output | 1 | Undo log holds its full depth |

## Verification
Two kinds of collision are driven on purpose. The first is a checkpoint and a write in the same cycle. The bench then takes another checkpoint and rolls back, so the result shows whether that write was logged in the new epoch. It also checks that the write counted against the space the checkpoint had just freed. The second is a rollback together with a write or a checkpoint: the bench reads every word afterwards and confirms that neither the write nor the checkpoint changed the restored state. These collisions also appear in the random sequence. There, a shadow model keeps snapshots of the last two checkpoints and predicts the outcome of every cycle.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;
    localparam int CK_ADDR_W = 4;
    localparam int CK_DATA_W = 8;
    localparam int CK_WORDS  = 2 ** CK_ADDR_W;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_UNDO = 1'b1
    } walk_state_e;

    typedef struct packed {
        logic                 epoch;
        logic [CK_ADDR_W-1:0] addr;
        logic [CK_DATA_W-1:0] old;
    } undo_rec_t;

    function automatic undo_rec_t make_rec(input logic ep,
                                           input logic [CK_ADDR_W-1:0] a,
                                           input logic [CK_DATA_W-1:0] d);
        undo_rec_t r;
        r.epoch = ep;
        r.addr  = a;
        r.old   = d;
        return r;
    endfunction
endpackage

// File: rtl/ckpt_word_store.sv
module ckpt_word_store
    import ckpt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [CK_ADDR_W-1:0] waddr,
    input  logic [CK_DATA_W-1:0] wdata,
    input  logic                 mark,
    input  logic                 clr_marks,
    input  logic [CK_ADDR_W-1:0] raddr,
    output logic [CK_DATA_W-1:0] rdata,
    output logic [CK_DATA_W-1:0] prior,
    output logic                 prior_marked
);
    logic [CK_DATA_W-1:0] words [CK_WORDS];
    logic [CK_WORDS-1:0]  touched;

    assign rdata        = words[raddr];
    assign prior        = words[waddr];
    assign prior_marked = touched[waddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CK_WORDS; i++) begin
                words[i] <= '0;
            end
            touched <= '0;
        end else begin
            if (we) begin
                words[waddr] <= wdata;
            end
            if (clr_marks) begin
                touched <= '0;
            end
            if (mark) begin
                touched[waddr] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ckpt_undo_ring.sv
module ckpt_undo_ring
    import ckpt_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             advance,
    input  logic             push,
    input  undo_rec_t        push_rec,
    input  logic             pop,
    output logic [CNT_W-1:0] cnt_old,
    output logic [CNT_W-1:0] cnt_cur,
    output undo_rec_t        top_rec
);
    undo_rec_t        ring [DEPTH];
    logic [PTR_W-1:0] head;
    logic [PTR_W-1:0] tail;

    assign top_rec = ring[tail - PTR_W'(1)];

    always_ff @(posedge clk) begin
        if (push) begin
            ring[tail] <= push_rec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head    <= '0;
            tail    <= '0;
            cnt_old <= '0;
            cnt_cur <= '0;
        end else if (pop) begin
            tail <= tail - PTR_W'(1);
            if (cnt_cur != '0) begin
                cnt_cur <= cnt_cur - CNT_W'(1);
            end else begin
                cnt_old <= cnt_old - CNT_W'(1);
            end
        end else begin
            if (push) begin
                tail <= tail + PTR_W'(1);
            end
            if (advance) begin
                head    <= head + cnt_old[PTR_W-1:0];
                cnt_old <= cnt_cur;
                cnt_cur <= push ? CNT_W'(1) : '0;
            end else if (push) begin
                cnt_cur <= cnt_cur + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/ckpt_mem.sv
module ckpt_mem
    import ckpt_pkg::*;
#(
    parameter int LOG_DEPTH = 16,
    localparam int CNT_W = $clog2(LOG_DEPTH) + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd_en,
    input  logic [CK_ADDR_W-1:0] rd_addr,
    output logic [CK_DATA_W-1:0] rd_data,
    input  logic                 wr_en,
    input  logic [CK_ADDR_W-1:0] wr_addr,
    input  logic [CK_DATA_W-1:0] wr_data,
    input  logic                 ckpt_strobe,
    input  logic                 rollback_strobe,
    output logic                 busy,
    output logic                 log_full
);
    walk_state_e          st;
    logic                 cur_epoch;
    logic [CNT_W-1:0]     cnt_old;
    logic [CNT_W-1:0]     cnt_cur;
    logic [CNT_W-1:0]     log_total;
    undo_rec_t            top_rec;
    logic [CK_DATA_W-1:0] store_rdata;
    logic [CK_DATA_W-1:0] prior;
    logic                 prior_marked;

    logic idle, rb_go, cp_go, need_log, room, wr_go, push, pop, walk_done;
    logic [CK_ADDR_W-1:0] st_addr;
    logic [CK_DATA_W-1:0] st_data;

    assign idle      = (st == ST_RUN);
    assign rb_go     = rollback_strobe && idle;
    assign cp_go     = ckpt_strobe && idle && !rollback_strobe;
    assign log_total = cnt_old + cnt_cur;
    // A checkpoint in the same cycle clears every mark, so the write needs an entry
    assign need_log  = cp_go || !prior_marked;
    assign room      = cp_go ? (cnt_cur != CNT_W'(LOG_DEPTH))
                             : (log_total != CNT_W'(LOG_DEPTH));
    assign wr_go     = wr_en && idle && !rollback_strobe && (!need_log || room);
    assign push      = wr_go && need_log;
    assign pop       = !idle && (log_total != '0);
    assign walk_done = !idle && (log_total == '0);
    assign st_addr   = pop ? top_rec.addr : wr_addr;
    assign st_data   = pop ? top_rec.old : wr_data;

    ckpt_word_store i_store (
        .clk          (clk),
        .rst          (rst),
        .we           (wr_go || pop),
        .waddr        (st_addr),
        .wdata        (st_data),
        .mark         (wr_go),
        .clr_marks    (cp_go || walk_done),
        .raddr        (rd_addr),
        .rdata        (store_rdata),
        .prior        (prior),
        .prior_marked (prior_marked)
    );

    ckpt_undo_ring #(.DEPTH(LOG_DEPTH)) i_ring (
        .clk      (clk),
        .rst      (rst),
        .flush    (walk_done),
        .advance  (cp_go),
        .push     (push),
        .push_rec (make_rec(cur_epoch ^ cp_go, wr_addr, prior)),
        .pop      (pop),
        .cnt_old  (cnt_old),
        .cnt_cur  (cnt_cur),
        .top_rec  (top_rec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_RUN;
            cur_epoch <= 1'b0;
            rd_data   <= '0;
        end else begin
            if (rb_go) begin
                st <= ST_UNDO;
            end else if (walk_done) begin
                st <= ST_RUN;
            end
            if (cp_go) begin
                cur_epoch <= ~cur_epoch;
            end
            if (rd_en && idle && !rollback_strobe) begin
                rd_data <= store_rdata;
            end
        end
    end

    assign busy     = !idle;
    assign log_full = (log_total == CNT_W'(LOG_DEPTH));
endmodule

// File: rtl/ckpt_mem_chk.sv
module ckpt_mem_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              log_full,
    input logic              ckpt_strobe,
    input logic              rollback_strobe,
    input logic [DATA_W-1:0] rd_data,
    input logic [CNT_W-1:0]  total
);
    AST_BUSY_ON_RB: assert property (@(posedge clk) disable iff (rst)
        !busy && rollback_strobe |=> busy); // R8
    AST_READ_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(rd_data)); // R8
    AST_WALK_STEP: assert property (@(posedge clk) disable iff (rst)
        busy && total != '0 |=> total == $past(total) - CNT_W'(1)); // R3
    AST_EMPTY_AFTER_UNDO: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> total == '0); // R3
    AST_LOG_BOUND: assert property (@(posedge clk) disable iff (rst)
        total <= CNT_W'(DEPTH)); // R10
    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (rst)
        log_full && !busy && !ckpt_strobe && !rollback_strobe |=> log_full); // R7
endmodule

bind ckpt_mem ckpt_mem_chk #(
    .DEPTH(LOG_DEPTH), .CNT_W(CNT_W), .DATA_W(ckpt_pkg::CK_DATA_W)
) i_ckpt_mem_chk (
    .clk             (clk),
    .rst             (rst),
    .busy            (busy),
    .log_full        (log_full),
    .ckpt_strobe     (ckpt_strobe),
    .rollback_strobe (rollback_strobe),
    .rd_data         (rd_data),
    .total           (log_total)
);

// File: tb/test_ckpt_mem.sv
module test_ckpt_mem;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rd_en = 1'b0, wr_en = 1'b0, ckpt_strobe = 1'b0, rollback_strobe = 1'b0;
    logic [3:0] rd_addr = '0, wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       busy, log_full;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_cur [16];
    logic [7:0] m_a   [16];
    logic [7:0] m_b   [16];
    bit         m_dirty [16];
    int         mo = 0, mc = 0;

    always #10 clk = ~clk;

    ckpt_mem i_ckpt_mem (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ckpt_strobe(ckpt_strobe), .rollback_strobe(rollback_strobe),
        .busy(busy), .log_full(log_full)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit model_full();
        return (mo + mc) == 16;
    endfunction

    task automatic model_apply(input bit we, input int a, input logic [7:0] d,
                               input bit cp, input bit rb);
        if (rb) begin
            m_cur = m_a;
            m_b   = m_a;
        end else begin
            if (cp) begin
                m_a = m_b;
                m_b = m_cur;
                mo  = mc;
                mc  = 0;
                foreach (m_dirty[i]) m_dirty[i] = 1'b0;
            end
            if (we) begin
                if (m_dirty[a] || (mo + mc) < 16) begin
                    m_cur[a] = d;
                    if (!m_dirty[a]) begin
                        mc++;
                        m_dirty[a] = 1'b1;
                    end
                end
            end
        end
    endtask

    task automatic read_word(input int a, output logic [7:0] v);
        rd_en   = 1'b1;
        rd_addr = a[3:0];
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic read_all(input string req);
        logic [7:0] v;
        for (int i = 0; i < 16; i++) begin
            read_word(i, v);
            chk(req, v, m_cur[i]);
        end
    endtask

    // Waits out a rollback walk; called at the negedge after the strobe edge
    task automatic finish_rollback(input int exp_busy);
        int n = 0;
        logic [7:0] hold;
        while (busy && n < 100) begin
            n++;
            hold    = rd_data;
            rd_en   = 1'b1;
            rd_addr = 4'($urandom % 16);
            wr_en   = 1'b1;
            wr_addr = rd_addr;
            wr_data = 8'hEE;
            @(posedge clk);
            @(negedge clk);
            chk("R8 rd_data frozen while busy", rd_data, hold);
        end
        rd_en = 1'b0;
        wr_en = 1'b0;
        chk("R8 busy cycles", n, exp_busy);
        mo = 0;
        mc = 0;
        foreach (m_dirty[i]) m_dirty[i] = 1'b0;
        chk("R8 log_full after walk", log_full, 0);
    endtask

    // Drives one cycle at a negedge, returns at the following negedge
    task automatic step(input bit we, input int a, input logic [7:0] d,
                        input bit cp, input bit rb);
        int exp_busy = mo + mc + 1;
        wr_en = we; wr_addr = a[3:0]; wr_data = d;
        ckpt_strobe = cp; rollback_strobe = rb;
        model_apply(we, a, d, cp, rb);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; ckpt_strobe = 1'b0; rollback_strobe = 1'b0;
        if (rb) begin
            chk("R8 busy after strobe", busy, 1);
            finish_rollback(exp_busy);
        end else begin
            chk("R10 log_full", log_full, model_full());
            chk("R8 idle", busy, 0);
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd4711));
        foreach (m_cur[i]) begin
            m_cur[i] = '0; m_a[i] = '0; m_b[i] = '0; m_dirty[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 log_full", log_full, 0);
        read_all("R1 reset contents");

        // R2 writes then reads
        for (int i = 0; i < 6; i++) step(1, i * 2, 8'(8'h10 + i), 0, 0);
        read_all("R2 readback");

        // R6 repeated writes to one word use one entry
        for (int i = 0; i < 20; i++) step(1, 3, 8'(i), 0, 0);
        chk("R6 no fill from rewrites", log_full, 0);
        read_word(3, v);
        chk("R6 last value", v, 19);

        // R3 rollback to reset checkpoint
        step(0, 0, 0, 0, 1);
        read_all("R3 restore");

        // R5 R7 R10 fill across two epochs
        for (int i = 0; i < 10; i++) step(1, i, 8'(8'h20 + i), 0, 0);
        step(0, 0, 0, 1, 0);
        for (int i = 10; i < 16; i++) step(1, i, 8'(8'h40 + i), 0, 0);
        chk("R10 full at 16", log_full, 1);
        step(1, 0, 8'h99, 0, 0);
        chk("R7 stays full", log_full, 1);
        read_word(0, v);
        chk("R7 stalled write not applied", v, 8'h20);
        step(1, 12, 8'h5C, 0, 0);
        read_word(12, v);
        chk("R7 rewrite applied while full", v, 8'h5C);
        step(0, 0, 0, 1, 0);
        chk("R5 checkpoint frees older epoch", log_full, 0);
        step(1, 0, 8'h99, 0, 0);
        read_word(0, v);
        chk("R5 write after free", v, 8'h99);

        // R4 rollback right after a checkpoint
        step(1, 7, 8'h71, 0, 0);
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 1);
        read_all("R4 window after checkpoint");

        // R9 checkpoint and write in one cycle
        step(1, 5, 8'hA5, 0, 0);
        step(1, 5, 8'hB6, 1, 0);
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 1);
        read_word(5, v);
        chk("R9 write joins new epoch", v, 8'hA5);
        // R9 rollback with write, then rollback with checkpoint
        step(1, 2, 8'h77, 0, 1);
        read_all("R9 rollback beats write");
        step(1, 9, 8'h33, 0, 0);
        step(0, 0, 0, 1, 1);
        read_all("R9 rollback beats checkpoint");

        // Random mix against the shadow model (R2 R3 R5 R6 R7 R10)
        for (int k = 0; k < 600; k++) begin
            int r = $urandom % 100;
            if (r < 62) step(1, $urandom % 16, 8'($urandom), 0, 0);
            else if (r < 70) step(1, $urandom % 16, 8'($urandom), 1, 0);
            else if (r < 82) step(0, 0, 0, 1, 0);
            else if (r < 86) begin
                step(0, 0, 0, 0, 1);
                read_all("R3 random rollback");
            end else begin
                int a = $urandom % 16;
                read_word(a, v);
                chk("R2 random read", v, m_cur[a]);
            end
        end
        read_all("R3 final contents");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule